// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Capture

This block watches a bank of general-purpose input pins and turns selected signal transitions into latched interrupt events. Every pin is brought into the system clock domain through a short synchronizer chain. A per-pin direction bit then decides whether a low-to-high or a high-to-low transition counts. A counted transition sets a sticky flag for that pin, and the flag stays set until software removes it by writing a one to that flag's bit.

Three configuration registers sit on a small register port alongside the flag register. One holds per-pin interrupt enables, one holds the edge direction, and one holds the digital input enable. While a pin's digital input is switched off, that pin cannot produce events. A single registered interrupt line is the OR of all flags that are also enabled. The flag register can be read and written at any time, and writes take effect on the next clock edge. Read data is combinational from the address.

Top module: `pin_irq_capture`

## Requirements
- R1: After synchronous reset, all four registers read 0x0000 and `irq` is 0.
- R2: `bus_addr` selects a register: 0 = interrupt enable, 1 = edge direction, 2 = input enable, 3 = flags. A write to address 0, 1 or 2 stores `bus_wdata`, and reading the same address returns the stored value.
- R3: A transition on pin i counts when its direction bit is 1 for low-to-high or 0 for high-to-low. If the pin changes just before clock edge k, flag i reads 1 after edge k+2 and still reads 0 after edge k+1.
- R4: A write to address 3 clears every flag whose `bus_wdata` bit is 1. Flags whose write bit is 0 keep their value.
- R5: If a counted transition and a clearing write reach the same flag at the same clock edge, the flag ends up 1.
- R6: While input-enable bit i is 0, no transition on pin i sets flag i.
- R7: Changing a direction bit, or setting an input-enable bit, while the pin is steady never sets a flag.
- R8: `irq` is registered. It equals the OR over all pins of (flag AND enable) as they stood one clock earlier, so it falls one cycle after the last enabled flag clears.
- R9: A flag stays at 1 after its pin returns to its former level, and it stays at 1 after further transitions of either direction, until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Asynchronous pin levels |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clearing write and a new counted transition arriving at the same flag on the same clock edge. To get there, the bench first sets the flag. It then returns the pin to its idle level, raises the pin again at a known negative edge, and counts two synchronizer stages before issuing the write, so that the write lands on exactly the edge where the new event is latched. False events on reconfiguration are checked in a similar way: the pin is held high while the direction bit is flipped and the input buffer is switched on, and the flags are then read back.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_POLARITY = 2'd1,
        SEL_INEN     = 2'd2,
        SEL_FLAGS    = 2'd3
    } reg_sel_e;

    // Configuration of one pin.
    typedef struct packed {
        logic irq_en;
        logic rise;     // 1: low-to-high counts, 0: high-to-low counts
        logic in_en;
    } pin_cfg_t;

    // Returns 1 when a transition from prev to cur matches the chosen direction.
    function automatic logic edge_match(input logic cur, input logic prev, input logic rise);
        logic changed;
        changed = cur ^ prev;
        return changed & (rise ? cur : ~cur);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect
    import pin_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_sel,
    input  logic [W-1:0] in_en,
    output logic [W-1:0] edge_hit
);
    logic [W-1:0] prev_q;

    // The previous sample tracks the pin every cycle, including while the
    // input is disabled, so switching the input on never shows a stale step.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign edge_hit[i] = in_en[i] & edge_match(level[i], prev_q[i], rise_sel[i]);
    end
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      edge_hit,
    output logic [W-1:0]      rise_sel,
    output logic [W-1:0]      in_en,
    output logic [W-1:0]      irq_en,
    output logic [W-1:0]      flags,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);
    pin_cfg_t [W-1:0] cfg_q;
    logic [W-1:0]     flags_q;
    logic [W-1:0]     clr_mask;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(bus_addr);

    for (genvar i = 0; i < W; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (bus_wr) begin
                case (sel)
                    SEL_ENABLE:   cfg_q[i].irq_en <= bus_wdata[i];
                    SEL_POLARITY: cfg_q[i].rise   <= bus_wdata[i];
                    SEL_INEN:     cfg_q[i].in_en  <= bus_wdata[i];
                    default:      ;
                endcase
            end
        end
        assign rise_sel[i] = cfg_q[i].rise;
        assign in_en[i]    = cfg_q[i].in_en;
        assign irq_en[i]   = cfg_q[i].irq_en;
    end

    // A clear and a new event on the same edge: the event wins.
    assign clr_mask = (bus_wr && sel == SEL_FLAGS) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_mask) | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(flags_q & irq_en);
    end

    always_comb begin
        case (sel)
            SEL_ENABLE:   bus_rdata = irq_en;
            SEL_POLARITY: bus_rdata = rise_sel;
            SEL_INEN:     bus_rdata = in_en;
            default:      bus_rdata = flags_q;
        endcase
    end

    assign flags = flags_q;
endmodule

// File: rtl/pin_irq_capture.sv
module pin_irq_capture
    import pin_irq_pkg::*;
#(
    parameter int N_PINS      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic              irq
);
    logic [N_PINS-1:0] level;
    logic [N_PINS-1:0] rise_vec;
    logic [N_PINS-1:0] inen_vec;
    logic [N_PINS-1:0] en_vec;
    logic [N_PINS-1:0] edge_hit;
    logic [N_PINS-1:0] flags_q;

    pin_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (pin_in),
        .synced (level)
    );

    pin_edge_detect #(.W(N_PINS)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .rise_sel (rise_vec),
        .in_en    (inen_vec),
        .edge_hit (edge_hit)
    );

    pin_irq_regs #(.W(N_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .edge_hit  (edge_hit),
        .rise_sel  (rise_vec),
        .in_en     (inen_vec),
        .irq_en    (en_vec),
        .flags     (flags_q),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );
endmodule

// File: rtl/pin_irq_capture_sva.sv
module pin_irq_capture_sva #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] flags,
    input logic [W-1:0] inen,
    input logic [W-1:0] en,
    input logic [W-1:0] edge_hit,
    input logic         irq
);
    logic flag_wr;
    assign flag_wr = bus_wr && (bus_addr == 2'd3);

    // R4: written ones clear flags that see no new event
    a_r4_clear_ones: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flags & $past(bus_wdata & ~edge_hit)) == '0));

    // R4: written zeros leave set flags alone
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> (($past(flags & ~bus_wdata) & ~flags) == '0));

    // R5: a detected event always lands in the flag
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (edge_hit != '0) |=> ((flags & $past(edge_hit)) == $past(edge_hit)));

    // R6: no event on a pin whose input is disabled
    always @(posedge clk) begin
        if (!rst) a_r6_inen_gate: assert ((edge_hit & ~inen) == '0);
    end

    // R8: registered combine of enabled flags
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == |($past(flags & en))));

    // R9: flags never fall without a flag write
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> (($past(flags) & ~flags) == '0));
endmodule

bind pin_irq_capture pin_irq_capture_sva #(.W(N_PINS)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags     (flags_q),
    .inen      (inen_vec),
    .en        (en_vec),
    .edge_hit  (edge_hit),
    .irq       (irq)
);

// File: tb/pin_irq_capture_test.sv
module pin_irq_capture_test;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pin_irq_capture uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [N-1:0] rise;
        logic [N-1:0] inen;
        logic [N-1:0] start;
        logic [N-1:0] fin;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{rise: 16'hFFFF, inen: 16'hFFFF, start: 16'h0000, fin: 16'h00FF},
        '{rise: 16'h0000, inen: 16'hFFFF, start: 16'hFFFF, fin: 16'h0F0F},
        '{rise: 16'hAAAA, inen: 16'hFFFF, start: 16'h5555, fin: 16'hAAAA},
        '{rise: 16'hFFFF, inen: 16'h00F0, start: 16'h0000, fin: 16'hFFFF},
        '{rise: 16'h0000, inen: 16'h8001, start: 16'hFFFF, fin: 16'h0000},
        '{rise: 16'hF0F0, inen: 16'hFFFF, start: 16'h0000, fin: 16'h0000}
    };

    function automatic logic [N-1:0] expect_flags(vec_t v);
        return v.inen & ((v.rise & ~v.start & v.fin) | (~v.rise & v.start & ~v.fin));
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    logic [N-1:0] r;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1 reset register", r, '0);
        end
        check("R1 reset irq", {15'd0, irq}, '0);

        // R2: register storage
        wr(2'd0, 16'h1234); wr(2'd1, 16'hBEEF); wr(2'd2, 16'h0F0F);
        rd(2'd0, r); check("R2 enable reg", r, 16'h1234);
        rd(2'd1, r); check("R2 polarity reg", r, 16'hBEEF);
        rd(2'd2, r); check("R2 input enable reg", r, 16'h0F0F);

        // R3/R6: table of direction and input-enable patterns
        wr(2'd0, 16'hFFFF);
        for (int v = 0; v < NV; v++) begin
            wr(2'd1, VECS[v].rise);
            wr(2'd2, VECS[v].inen);
            pin_in = VECS[v].start;
            cyc(5);
            wr(2'd3, 16'hFFFF);
            cyc(2);
            pin_in = VECS[v].fin;
            cyc(5);
            rd(2'd3, r);
            check("R3 R6 flags from vector", r, expect_flags(VECS[v]));
            check("R8 irq from vector", {15'd0, irq}, {15'd0, |expect_flags(VECS[v])});
        end

        // R3: exact latency, R8 irq one cycle later
        wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF); wr(2'd0, 16'h0001);
        pin_in = '0; cyc(5); wr(2'd3, 16'hFFFF); cyc(3);
        pin_in[0] = 1'b1;
        cyc(1);
        cyc(1); rd(2'd3, r); check("R3 flag not yet after k+1", r, '0);
        cyc(1); rd(2'd3, r); check("R3 flag set after k+2", r, 16'h0001);
        check("R8 irq still low after k+2", {15'd0, irq}, '0);
        cyc(1); check("R8 irq high after k+3", {15'd0, irq}, 16'h0001);

        // R9: pin returns low, flag stays
        pin_in[0] = 1'b0; cyc(5);
        rd(2'd3, r); check("R9 flag sticky", r, 16'h0001);

        // R4: writing zero keeps the flag
        wr(2'd3, 16'h0000);
        rd(2'd3, r); check("R4 write zero keeps flag", r, 16'h0001);

        // R5: clear coincides with a new event
        pin_in[0] = 1'b1;        // edge k
        cyc(1);                  // after k
        cyc(1);                  // after k+1
        wr(2'd3, 16'h0001);      // write lands on k+2 with the event
        rd(2'd3, r); check("R5 set wins over clear", r, 16'h0001);

        // R4 and R8: clear, irq falls one cycle later
        bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd3, r); check("R4 write one clears", r, '0);
        check("R8 irq one more cycle", {15'd0, irq}, 16'h0001);
        cyc(1); check("R8 irq falls", {15'd0, irq}, '0);

        // R8: flag without enable gives no irq
        wr(2'd0, 16'h0000);
        pin_in[1] = 1'b1; cyc(5);
        rd(2'd3, r); check("R8 masked flag set", r, 16'h0002);
        check("R8 masked irq low", {15'd0, irq}, '0);
        wr(2'd3, 16'hFFFF);

        // R7: pins held high, flip direction and enable input buffers
        wr(2'd2, 16'h0000);
        pin_in = 16'hFFFF; cyc(5);
        wr(2'd3, 16'hFFFF);
        wr(2'd2, 16'hFFFF); cyc(4);
        rd(2'd3, r); check("R7 no event on input enable", r, '0);
        wr(2'd1, 16'h0000); cyc(4);
        wr(2'd1, 16'hFFFF); cyc(4);
        rd(2'd3, r); check("R7 no event on direction change", r, '0);

        // R1: reset again clears state
        rst = 1'b1; cyc(2); rst = 1'b0;
        rd(2'd2, r); check("R1 reset clears input enable", r, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule